// File: doc/BRIEF.md
# Cross-Cluster Store-to-Load Ordering Checker

This block joins the store queues of two execution clusters so that a single program-ordered instruction window split across them keeps correct memory ordering. Cluster 0 runs the older batch of instructions and cluster 1 the younger batch. Because the batches follow program order, every store held by cluster 0 is older than every load issued by cluster 1. Within cluster 1, a store is older than a load if it lies between the queue head and the tail position the load recorded at dispatch.

When a cluster-1 load knows its address, the block first searches that cluster's own queue. The search runs from the youngest older store down to the oldest. If the local queue cannot decide the outcome, one lookup goes to cluster 0's queue and returns after a fixed delay. Each load receives one of four answers: wait, data forwarded from the local queue, data forwarded from the older cluster, or permission to read memory. A conservative mode makes a load wait while any earlier store in either cluster still lacks an address.

Top module: `xcluster_stld`

## Requirements
- R1: After reset, `ld_rdy` is 1 and `resp_vld`, `xq_busy` and `old_unk` are 0.
- R2: `old_unk` is 1 exactly when cluster 0 holds an allocated store whose address has not been resolved.
- R3: With `cons_mode`=1, an accepted load gets `resp_kind`=0 (wait) in the cycle after acceptance if any older cluster-1 store or any cluster-0 store has an unknown address.
- R4: A load is accepted when `ld_req` and `ld_rdy` are both 1. If the local search ends on a fully covering store, the block answers `resp_kind`=1 in the next cycle, and `xq_busy` stays 0 throughout.
- R5: If the deciding store overlaps only some of the load's bytes, the answer is `resp_kind`=0.
- R6: The local search is decided by the youngest older store that either matches or has an unknown address. An unknown store younger than a full match gives wait; a full match younger than an unknown store forwards (when `cons_mode`=0).
- R7: If no local store decides the outcome, `xq_busy` goes high for exactly REM_LAT cycles and `ld_rdy` stays low while it is high. The response comes in the cycle `xq_busy` falls, REM_LAT+1 cycles after acceptance.
- R8: A remote lookup treats every cluster-0 store as older than the load and applies the youngest-decides rule. A full match gives `resp_kind`=2; a partial match or an unknown address gives 0.
- R9: When neither queue decides the outcome, the answer is `resp_kind`=3 (memory). Whenever `resp_kind` is 0 or 3, `resp_data` is 0.
- R10: A store matches a load when the word addresses are equal and the byte masks (bit b covers bits 8b+7..8b of the word) overlap. Forwarded data is the store's word with the bytes outside the load's mask set to zero.
- R11: Cluster-1 stores at or beyond the load's `ld_tail` (a pointer with a wrap bit) are younger than the load and have no effect on its answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cons_mode | input | 1 | 1: wait on any unknown earlier store address |
| st_alloc | input | 2 | Per-cluster store allocation at the queue tail |
| st_commit | input | 2 | Per-cluster removal of the queue head |
| st_resolve | input | 2 | Per-cluster address/data resolve strobe |
| st_idx | input | 2xPW | Queue slot to resolve, per cluster |
| st_addr | input | 2xAW | Word address, per cluster |
| st_mask | input | 2xDW/8 | Byte mask, per cluster |
| st_data | input | 2xDW | Store data, per cluster |
| ld_req | input | 1 | Cluster-1 load with resolved address |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Load byte mask |
| ld_tail | input | PW+1 | Cluster-1 queue tail recorded at load dispatch |
| ld_rdy | output | 1 | Block can accept a load |
| old_unk | output | 1 | Cluster 0 holds a store of unknown address |
| xq_busy | output | 1 | Lookup to cluster 0 outstanding |
| resp_vld | output | 1 | One-cycle response strobe |
| resp_kind | output | 2 | 0 wait, 1 local forward, 2 older-cluster forward, 3 memory |
| resp_data | output | DW | Forwarded data |

## Verification
The properties assume DEPTH is a power of two and that neither queue is allocated beyond its depth. They also assume that resolves target allocated slots and that `ld_tail` lies between the cluster-1 head and tail. The stimulus keeps at most five stores per cluster window: two in cluster 0, and up to three in cluster 1 after a wrap offset of at most three. It resets the block before every case and never commits an empty queue. Under these limits, every accepted load gets exactly one answer, and a remote lookup has a fixed length.

// File: rtl/xcluster_stld.sv
module xcluster_stld #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int REM_LAT = 3,
  localparam int PW = $clog2(DEPTH),
  localparam int PW1 = PW + 1,
  localparam int NB = DW / 8,
  localparam int CW = $clog2(REM_LAT + 1)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cons_mode,
  input  logic [1:0]             st_alloc,
  input  logic [1:0]             st_commit,
  input  logic [1:0]             st_resolve,
  input  logic [1:0][PW-1:0]     st_idx,
  input  logic [1:0][AW-1:0]     st_addr,
  input  logic [1:0][NB-1:0]     st_mask,
  input  logic [1:0][DW-1:0]     st_data,
  input  logic                   ld_req,
  input  logic [AW-1:0]          ld_addr,
  input  logic [NB-1:0]          ld_mask,
  input  logic [PW:0]            ld_tail,
  output logic                   ld_rdy,
  output logic                   old_unk,
  output logic                   xq_busy,
  output logic                   resp_vld,
  output logic [1:0]             resp_kind,
  output logic [DW-1:0]          resp_data
);

  localparam logic [1:0] K_WAIT = 2'd0, K_LOCAL = 2'd1, K_REMOTE = 2'd2, K_MEM = 2'd3;
  localparam logic [1:0] S_NONE = 2'd0, S_WAIT = 2'd1, S_FWD = 2'd2;
  localparam logic [PW:0] FULL_N = PW1'(DEPTH);

  logic          ev [2][DEPTH];
  logic          ek [2][DEPTH];
  logic [AW-1:0] ea [2][DEPTH];
  logic [NB-1:0] em [2][DEPTH];
  logic [DW-1:0] ed [2][DEPTH];
  logic [PW:0]   hd [2];
  logic [PW:0]   tl [2];

  logic          busy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] q_addr;
  logic [NB-1:0] q_mask;

  logic [1:0]    loc_res, rem_res;
  logic [DW-1:0] loc_dat, rem_dat;
  logic          loc_unk;

  function automatic logic [DW-1:0] bytes_of(input logic [NB-1:0] m);
    logic [DW-1:0] e;
    for (int b = 0; b < NB; b++) e[b*8 +: 8] = {8{m[b]}};
    return e;
  endfunction

  // youngest-decides search over the n oldest entries of cluster c
  function automatic logic [DW+1:0] scan(input int c, input logic [PW:0] n,
                                         input logic [AW-1:0] la, input logic [NB-1:0] lm);
    logic [1:0]    r;
    logic [DW-1:0] dd;
    logic [PW:0]   s;
    r  = S_NONE;
    dd = '0;
    for (int a = 0; a < DEPTH; a++) begin
      s = hd[c] + PW1'(a);
      if (a < int'(n) && ev[c][s[PW-1:0]]) begin
        if (!ek[c][s[PW-1:0]]) begin
          r  = S_WAIT;
          dd = '0;
        end else if (ea[c][s[PW-1:0]] == la && |(em[c][s[PW-1:0]] & lm)) begin
          if ((lm & ~em[c][s[PW-1:0]]) == '0) begin
            r  = S_FWD;
            dd = ed[c][s[PW-1:0]] & bytes_of(lm);
          end else begin
            r  = S_WAIT;
            dd = '0;
          end
        end
      end
    end
    return {r, dd};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        hd[c] <= '0;
        tl[c] <= '0;
        for (int i = 0; i < DEPTH; i++) begin
          ev[c][i] <= 1'b0;
          ek[c][i] <= 1'b0;
          ea[c][i] <= '0;
          em[c][i] <= '0;
          ed[c][i] <= '0;
        end
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (st_resolve[c] && ev[c][st_idx[c]]) begin
          ek[c][st_idx[c]] <= 1'b1;
          ea[c][st_idx[c]] <= st_addr[c];
          em[c][st_idx[c]] <= st_mask[c];
          ed[c][st_idx[c]] <= st_data[c];
        end
        if (st_alloc[c] && (tl[c] - hd[c]) != FULL_N) begin
          ev[c][tl[c][PW-1:0]] <= 1'b1;
          ek[c][tl[c][PW-1:0]] <= 1'b0;
          tl[c] <= tl[c] + 1'b1;
        end
        if (st_commit[c] && hd[c] != tl[c]) begin
          ev[c][hd[c][PW-1:0]] <= 1'b0;
          hd[c] <= hd[c] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    old_unk = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (ev[0][i] && !ek[0][i]) old_unk = 1'b1;
  end

  always_comb begin : local_unknown
    logic [PW:0] s;
    logic [PW:0] nold;
    nold    = ld_tail - hd[1];
    loc_unk = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      s = hd[1] + PW1'(a);
      if (a < int'(nold) && ev[1][s[PW-1:0]] && !ek[1][s[PW-1:0]]) loc_unk = 1'b1;
    end
  end

  assign {loc_res, loc_dat} = scan(1, ld_tail - hd[1], ld_addr, ld_mask);
  assign {rem_res, rem_dat} = scan(0, tl[0] - hd[0], q_addr, q_mask);

  assign ld_rdy  = !busy;
  assign xq_busy = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      q_addr    <= '0;
      q_mask    <= '0;
      resp_vld  <= 1'b0;
      resp_kind <= K_WAIT;
      resp_data <= '0;
    end else begin
      resp_vld <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy     <= 1'b0;
          resp_vld <= 1'b1;
          case (rem_res)
            S_FWD:   begin resp_kind <= K_REMOTE; resp_data <= rem_dat; end
            S_WAIT:  begin resp_kind <= K_WAIT;   resp_data <= '0;      end
            default: begin resp_kind <= K_MEM;    resp_data <= '0;      end
          endcase
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (ld_req) begin
        q_addr <= ld_addr;
        q_mask <= ld_mask;
        if (cons_mode && (loc_unk || old_unk)) begin
          resp_vld  <= 1'b1;
          resp_kind <= K_WAIT;
          resp_data <= '0;
        end else if (loc_res == S_WAIT) begin
          resp_vld  <= 1'b1;
          resp_kind <= K_WAIT;
          resp_data <= '0;
        end else if (loc_res == S_FWD) begin
          resp_vld  <= 1'b1;
          resp_kind <= K_LOCAL;
          resp_data <= loc_dat;
        end else begin
          busy <= 1'b1;
          cnt  <= CW'(REM_LAT - 1);
        end
      end
    end
  end

endmodule

// File: rtl/xcluster_stld_sva.sv
module xcluster_stld_sva #(
  parameter int DW = 32,
  parameter int REM_LAT = 3
)(
  input logic          clk,
  input logic          rst_n,
  input logic          cons_mode,
  input logic          ld_req,
  input logic          ld_rdy,
  input logic          old_unk,
  input logic          xq_busy,
  input logic          resp_vld,
  input logic [1:0]    resp_kind,
  input logic [DW-1:0] resp_data
);

  logic [15:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (xq_busy) busy_len <= busy_len + 16'd1;
    else busy_len <= '0;
  end

  p_cons_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_rdy && cons_mode && old_unk) |=> (resp_vld && resp_kind == 2'd0));

  p_local_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_rdy) |=> (!resp_vld || resp_kind == 2'd0 || resp_kind == 2'd1));

  p_one_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_rdy) |=> (resp_vld != xq_busy));

  p_remote_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xq_busy) |-> (resp_vld && busy_len == 16'(REM_LAT)));

  p_remote_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xq_busy) |-> (resp_kind != 2'd1));

  p_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && (resp_kind == 2'd0 || resp_kind == 2'd3)) |-> (resp_data == '0));

endmodule

bind xcluster_stld xcluster_stld_sva #(.DW(DW), .REM_LAT(REM_LAT)) u_sva (
  .clk(clk), .rst_n(rst_n), .cons_mode(cons_mode), .ld_req(ld_req), .ld_rdy(ld_rdy),
  .old_unk(old_unk), .xq_busy(xq_busy), .resp_vld(resp_vld), .resp_kind(resp_kind),
  .resp_data(resp_data)
);

// File: tb/sim_xcluster_stld.sv
module sim_xcluster_stld;
  localparam int AW = 8, DW = 32, DEPTH = 4, REM_LAT = 3, PW = 2, NB = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_n, cons_mode, ld_req;
  logic [1:0]          st_alloc, st_commit, st_resolve;
  logic [1:0][PW-1:0]  st_idx;
  logic [1:0][AW-1:0]  st_addr;
  logic [1:0][NB-1:0]  st_mask;
  logic [1:0][DW-1:0]  st_data;
  logic [AW-1:0]       ld_addr;
  logic [NB-1:0]       ld_mask;
  logic [PW:0]         ld_tail;
  logic                ld_rdy, old_unk, xq_busy, resp_vld;
  logic [1:0]          resp_kind;
  logic [DW-1:0]       resp_data;

  int n_run = 0, n_fail = 0;

  xcluster_stld #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .REM_LAT(REM_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .cons_mode(cons_mode), .st_alloc(st_alloc), .st_commit(st_commit),
    .st_resolve(st_resolve), .st_idx(st_idx), .st_addr(st_addr), .st_mask(st_mask),
    .st_data(st_data), .ld_req(ld_req), .ld_addr(ld_addr), .ld_mask(ld_mask), .ld_tail(ld_tail),
    .ld_rdy(ld_rdy), .old_unk(old_unk), .xq_busy(xq_busy), .resp_vld(resp_vld),
    .resp_kind(resp_kind), .resp_data(resp_data));

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] bexp(input logic [NB-1:0] m);
    logic [DW-1:0] e;
    for (int b = 0; b < NB; b++) e[b*8 +: 8] = {8{m[b]}};
    return e;
  endfunction

  task automatic idle_inputs();
    st_alloc = '0; st_commit = '0; st_resolve = '0; st_idx = '0; st_addr = '0;
    st_mask = '0; st_data = '0; ld_req = 1'b0; ld_addr = '0; ld_mask = '0; ld_tail = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc(input logic [1:0] w);
    st_alloc = w; @(negedge clk); st_alloc = '0;
  endtask

  task automatic commit(input logic [1:0] w);
    st_commit = w; @(negedge clk); st_commit = '0;
  endtask

  task automatic resolve(input int c, input int idx, input logic [AW-1:0] a,
                         input logic [NB-1:0] m, input logic [DW-1:0] d);
    st_resolve[c] = 1'b1; st_idx[c] = PW'(idx); st_addr[c] = a; st_mask[c] = m; st_data[c] = d;
    @(negedge clk);
    st_resolve = '0;
  endtask

  task automatic run_load(input logic [AW-1:0] a, input logic [NB-1:0] m, input logic [PW:0] t,
                          input logic [1:0] ek, input logic [DW-1:0] ed, input int el, input string tag);
    int  n;
    bit  busy_seen;
    chk(ld_rdy == 1'b1, {tag, " ready"}, DW'(ld_rdy), 1);
    ld_req = 1'b1; ld_addr = a; ld_mask = m; ld_tail = t;
    @(negedge clk);
    ld_req = 1'b0;
    n = 1;
    busy_seen = 1'b0;
    while (!resp_vld && n < 12) begin
      busy_seen |= xq_busy;
      if (xq_busy) chk(ld_rdy == 1'b0, "R7 busy blocks", DW'(ld_rdy), 0);
      @(negedge clk);
      n++;
    end
    chk(resp_kind == ek, {tag, " kind"}, DW'(resp_kind), DW'(ek));
    chk(resp_data == ed, {tag, " R10 data"}, resp_data, ed);
    chk(n == el, "R7 latency", DW'(n), DW'(el));
    chk(busy_seen == (el > 1), "R4 R7 remote traffic", DW'(busy_seen), DW'(el > 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cons_mode = 1'b0;
    idle_inputs();
    do_reset();
    chk(ld_rdy == 1'b1, "R1 ld_rdy", DW'(ld_rdy), 1);
    chk(resp_vld == 1'b0, "R1 resp_vld", DW'(resp_vld), 0);
    chk(xq_busy == 1'b0, "R1 xq_busy", DW'(xq_busy), 0);
    chk(old_unk == 1'b0, "R1 old_unk", DW'(old_unk), 0);

    // single-store sweep: cluster, address match, every store mask x load mask
    for (int c = 0; c < 2; c++)
      for (int same = 0; same < 2; same++)
        for (int sm = 1; sm < 16; sm++)
          for (int lm = 1; lm < 16; lm++) begin
            logic [DW-1:0] sd, xd;
            logic [1:0]    xk;
            int            xl;
            string         tg;
            bit            hit, full;
            do_reset();
            cons_mode = 1'b0;
            sd = 32'h1357_9BDF ^ DW'(sm << 8);
            alloc(c == 1 ? 2'b10 : 2'b01);
            if (c == 0) chk(old_unk == 1'b1, "R2 unknown set", DW'(old_unk), 1);
            resolve(c, 0, 8'h21, NB'(sm), sd);
            chk(old_unk == 1'b0, "R2 unknown clear", DW'(old_unk), 0);
            hit  = same && ((sm & lm) != 0);
            full = (lm & ~sm & 15) == 0;
            if (!hit) begin xk = 2'd3; xd = '0; xl = REM_LAT + 1; tg = "R9"; end
            else if (!full) begin xk = 2'd0; xd = '0; xl = (c == 1) ? 1 : REM_LAT + 1; tg = "R5"; end
            else begin
              xk = (c == 1) ? 2'd1 : 2'd2;
              xd = sd & bexp(NB'(lm));
              xl = (c == 1) ? 1 : REM_LAT + 1;
              tg = (c == 1) ? "R4" : "R8";
            end
            run_load(same ? 8'h21 : 8'h22, NB'(lm), (c == 1) ? 3'd1 : 3'd0, xk, xd, xl, tg);
          end

    // ordering sweep: 3 local stores x 2 older-cluster stores, each unknown/full/none/partial
    for (int lc = 0; lc < 64; lc++)
      for (int rc = 0; rc < 16; rc++)
        for (int cm = 0; cm < 2; cm++)
          for (int ts = 0; ts < 2; ts++) begin
            int ls [3];
            int rs [2];
            int off, nold, xl;
            bit lunk, runk;
            logic [1:0] lres, xk;
            logic [DW-1:0] xd;
            string tg;
            for (int a = 0; a < 3; a++) ls[a] = (lc >> (2 * a)) & 3;
            for (int j = 0; j < 2; j++) rs[j] = (rc >> (2 * j)) & 3;
            off  = (lc + rc + cm) % 4;
            nold = 2 + ts;
            do_reset();
            cons_mode = cm[0];
            for (int k = 0; k < off; k++) begin
              alloc(2'b10);
              commit(2'b10);
            end
            for (int a = 0; a < 3; a++) alloc({1'b1, a < 2});
            for (int a = 0; a < 3; a++)
              if (ls[a] != 0)
                resolve(1, (off + a) % 4, ls[a] == 2 ? 8'h09 : 8'h05,
                        ls[a] == 3 ? 4'h6 : 4'hF, {4{8'h10 + 8'(a)}});
            for (int j = 0; j < 2; j++)
              if (rs[j] != 0)
                resolve(0, j, rs[j] == 2 ? 8'h09 : 8'h05,
                        rs[j] == 3 ? 4'h6 : 4'hF, {4{8'hA0 + 8'(j)}});
            runk = (rs[0] == 0) || (rs[1] == 0);
            chk(old_unk == runk, "R2 older unknown", DW'(old_unk), DW'(runk));
            lunk = 1'b0;
            lres = 2'd0;
            xd   = '0;
            for (int a = 0; a < nold; a++) begin
              if (ls[a] == 0) lunk = 1'b1;
              if (ls[a] == 0 || ls[a] == 3) begin lres = 2'd1; xd = '0; end
              else if (ls[a] == 1) begin lres = 2'd2; xd = {16'h0, {2{8'h10 + 8'(a)}}}; end
            end
            if (cm == 1 && (lunk || runk)) begin
              xk = 2'd0; xd = '0; xl = 1; tg = "R3";
            end else if (lres != 2'd0) begin
              xk = (lres == 2'd2) ? 2'd1 : 2'd0; xl = 1; tg = "R6 R11";
            end else begin
              lres = 2'd0;
              for (int j = 0; j < 2; j++) begin
                if (rs[j] == 0 || rs[j] == 3) begin lres = 2'd1; xd = '0; end
                else if (rs[j] == 1) begin lres = 2'd2; xd = {16'h0, {2{8'hA0 + 8'(j)}}}; end
              end
              xl = REM_LAT + 1;
              if (lres == 2'd2) begin xk = 2'd2; tg = "R8"; end
              else if (lres == 2'd1) begin xk = 2'd0; tg = "R8"; end
              else begin xk = 2'd3; xd = '0; tg = "R9"; end
            end
            run_load(8'h05, 4'h3, 3'((off + nold) % 8), xk, xd, xl, tg);
          end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule